// File: doc/BRIEF.md
# Bus Wait-State Controller

This block sets the length, in bus clock cycles, of every memory access. When a request arrives, the block looks at three things: the target region (special-function register space, display RAM, internal program/data memory, or external space behind one of four chip selects), the bus mode of the external access (separate or multiplexed), and two software wait controls. The first control is a global wait bit. The second is a per-chip-select wait field. The block then drives a strobe for each bus cycle, adds stall cycles while the ready input is low, and pulses done on the final cycle.

The wait controls live in three small registers behind a simple register port:

| Address | Register | Field |
|---|---|---|
| 0 | Mode register | Global wait bit at bit 7 |
| 1 | Chip-select wait register | Per-chip-select bits at bits 7:4 (bit 4+n belongs to chip select n) |
| 2 | Protect register | Unlock bit at bit 1 |

The mode register accepts a write only while the unlock bit is set. Address decoding and the data path sit outside this block.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset all three registers read 0 and busy_o, bus_strb_o and done_o are low.
- R2: Accesses to region code 0 (special-function registers) or region code 1 (display RAM) always last 2 cycles, for any wait setting or bus mode.
- R3: Accesses to region code 2 (internal memory) last 1 cycle when the global wait bit is 0 and 2 cycles when it is 1.
- R4: An external access (region code 3) with mux_bus_i=0 lasts 1 cycle only when the global wait bit is 0 and the chip-select bit at bit 4+cs_sel_i of address 1 is 1. Otherwise it lasts 2 cycles.
- R5: An external access with mux_bus_i=1 always lasts 3 cycles.
- R6: A write to address 0 takes effect only while bit 1 of address 2 is 1. Any other write to address 0 leaves the mode register unchanged.
- R7: When the base length is 2 or more, each cycle in which rdy_i is low on the final cycle adds one cycle, and done_o rises only in a cycle with rdy_i high. A 1-cycle access ignores rdy_i.
- R8: A request is accepted only while busy_o is low. Requests made during an access are ignored, and the cycle after done_o always shows busy_o low.
- R9: bus_strb_o and busy_o are high in every cycle of an access. done_o is high only in the last one.
- R10: Reads return the mode register at bit 7 of address 0, the chip-select field at bits 7:4 of address 1 and the unlock bit at bit 1 of address 2. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| region_i | input | 2 | Target region code (0 special registers, 1 display RAM, 2 internal memory, 3 external) |
| cs_sel_i | input | 2 | Chip select of an external access |
| mux_bus_i | input | 1 | 1 when the external access uses the multiplexed bus |
| rdy_i | input | 1 | Ready from the target; low stretches a waited access |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| bus_strb_o | output | 1 | High during each bus cycle of an access |
| done_o | output | 1 | High in the final cycle of an access |
| busy_o | output | 1 | Access in progress; new requests are held off |

## Verification
Directed accesses sweep every region with the global bit clear and then set. Each chip select is tried in both bus modes with its field bit on and off. These runs separate the 1-, 2- and 3-cycle outcomes and show whether the global bit overrides the per-select bit. Further directed runs cover ready stalls on waited accesses, a low ready on a 1-cycle access (which must be ignored), and a request held high through an access. Locked and unlocked writes to the mode register show whether the protect gate works. Seeded random sequences then mix register writes with accesses across all settings and compare each access length against a bench model.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;
  typedef enum logic [1:0] {
    RGN_SFR  = 2'd0,
    RGN_DISP = 2'd1,
    RGN_IMEM = 2'd2,
    RGN_EXT  = 2'd3
  } region_e;

  localparam int REG_AW = 2;
  localparam int REG_DW = 8;
  localparam logic [REG_AW-1:0] ADDR_MODE = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_CSW  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_PROT = 2'd2;
  localparam int WAIT_BIT = 7;
  localparam int CSW_LSB  = 4;
  localparam int PROT_BIT = 1;

  localparam int LEN_W = 2;
  localparam logic [LEN_W-1:0] LEN_FAST  = 2'd1;
  localparam logic [LEN_W-1:0] LEN_WAIT  = 2'd2;
  localparam logic [LEN_W-1:0] LEN_MUX   = 2'd3;
endpackage

// File: rtl/bus_wait_regs.sv
module bus_wait_regs
  import bus_wait_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              wait_o,
  output logic [NUM_CS-1:0] csw_o
);
  logic              wait_q;
  logic              prot_q;
  logic [NUM_CS-1:0] csw_q;
  logic              mode_wr;

  assign mode_wr = we_i && (addr_i == ADDR_MODE) && prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wait_q <= 1'b0;
    else if (mode_wr) wait_q <= wdata_i[WAIT_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              prot_q <= 1'b0;
    else if (we_i && addr_i == ADDR_PROT)     prot_q <= wdata_i[PROT_BIT];
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          csw_q[g] <= 1'b0;
      else if (we_i && addr_i == ADDR_CSW)  csw_q[g] <= wdata_i[CSW_LSB+g];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_MODE: rdata_o[WAIT_BIT] = wait_q;
      ADDR_CSW:  rdata_o[CSW_LSB +: NUM_CS] = csw_q;
      ADDR_PROT: rdata_o[PROT_BIT] = prot_q;
      default:   rdata_o = '0;
    endcase
  end

  assign wait_o = wait_q;
  assign csw_o  = csw_q;

  a_r6_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_MODE && !prot_q) |=> $stable(wait_q));
  a_r6_mode_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_MODE && prot_q) |=> (wait_q == $past(wdata_i[WAIT_BIT])));
endmodule

// File: rtl/bus_wait_calc.sv
module bus_wait_calc
  import bus_wait_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [1:0]        region_i,
  input  logic [CS_W-1:0]   cs_sel_i,
  input  logic              mux_i,
  input  logic              wait_i,
  input  logic [NUM_CS-1:0] csw_i,
  output logic [LEN_W-1:0]  len_o
);
  region_e rgn;
  logic    cs_fast;

  assign rgn     = region_e'(region_i);
  assign cs_fast = csw_i[cs_sel_i];

  always_comb begin
    unique case (rgn)
      RGN_SFR, RGN_DISP: len_o = LEN_WAIT;
      RGN_IMEM:          len_o = wait_i ? LEN_WAIT : LEN_FAST;
      RGN_EXT: begin
        if (mux_i)                   len_o = LEN_MUX;
        else if (!wait_i && cs_fast) len_o = LEN_FAST;
        else                         len_o = LEN_WAIT;
      end
      default:                       len_o = LEN_WAIT;
    endcase
  end
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bus_wait_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rdy_i,
  output logic             strb_o,
  output logic             done_o,
  output logic             busy_o
);
  logic             active_q;
  logic             multi_q;
  logic [LEN_W-1:0] cnt_q;
  logic             accept;
  logic             last_cyc;

  assign accept   = !active_q && req_i;
  assign last_cyc = active_q && (cnt_q == LEN_FAST);
  assign done_o   = last_cyc && (rdy_i || !multi_q);
  assign strb_o   = active_q;
  assign busy_o   = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      multi_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      multi_q  <= (len_i != LEN_FAST);
      cnt_q    <= len_i;
    end else if (active_q) begin
      if (cnt_q != LEN_FAST) cnt_q    <= cnt_q - 1'b1;
      else if (done_o)       active_q <= 1'b0;
    end
  end

  a_r7_done_needs_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && multi_q) |-> rdy_i);
  a_r8_start_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));
  a_r8_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r9_done_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && strb_o));
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bus_wait_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        region_i,
  input  logic [CS_W-1:0]   cs_sel_i,
  input  logic              mux_bus_i,
  input  logic              rdy_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              bus_strb_o,
  output logic              done_o,
  output logic              busy_o
);
  logic              wait_bit;
  logic [NUM_CS-1:0] csw;
  logic [LEN_W-1:0]  len;

  bus_wait_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .wait_o  (wait_bit),
    .csw_o   (csw)
  );

  bus_wait_calc #(.NUM_CS(NUM_CS)) u_calc (
    .region_i (region_i),
    .cs_sel_i (cs_sel_i),
    .mux_i    (mux_bus_i),
    .wait_i   (wait_bit),
    .csw_i    (csw),
    .len_o    (len)
  );

  bus_wait_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .len_i  (len),
    .rdy_i  (rdy_i),
    .strb_o (bus_strb_o),
    .done_o (done_o),
    .busy_o (busy_o)
  );

  a_r2_fixed_regions: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && region_i inside {2'd0, 2'd1}) |-> (len == LEN_WAIT));
  a_r5_mux_three: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && region_i == 2'd3 && mux_bus_i) |-> (len == LEN_MUX));
  a_r3_global_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && wait_bit) |-> (len != LEN_FAST));
endmodule

// File: tb/bus_wait_ctrl_tb.sv
`timescale 1ns/1ps
module bus_wait_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [1:0] region_i = '0;
  logic [1:0] cs_sel_i = '0;
  logic       mux_bus_i = 1'b0;
  logic       rdy_i = 1'b1;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       bus_strb_o, done_o, busy_o;

  int checks = 0;
  int failures = 0;
  logic       m_wait = 1'b0;
  logic       m_prot = 1'b0;
  logic [3:0] m_csw = '0;

  always #4 clk_i = ~clk_i;

  bus_wait_ctrl u_dut (.*);

  function automatic int exp_len(logic [1:0] rg, logic [1:0] cs, logic mx);
    if (rg == 2'd0 || rg == 2'd1) return 2;
    if (rg == 2'd2) return m_wait ? 2 : 1;
    if (mx) return 3;
    return (!m_wait && m_csw[cs]) ? 1 : 2;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a == 2'd0 && m_prot) m_wait = d[7];
    if (a == 2'd1) m_csw = d[7:4];
    if (a == 2'd2) m_prot = d[1];
  endtask

  task automatic rd_check(string req, logic [1:0] a, logic [7:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    check(req, int'(reg_rdata_o), int'(exp));
  endtask

  // stall: ready-low cycles offered from the final base cycle on
  task automatic access(string req, logic [1:0] rg, logic [1:0] cs, logic mx,
                        int stall, bit hold_req);
    int base, n, left, exp;
    bit bad;
    base = exp_len(rg, cs, mx);
    exp = base + ((base >= 2) ? stall : 0);
    left = stall; n = 0; bad = 0;
    @(negedge clk_i);
    region_i = rg; cs_sel_i = cs; mux_bus_i = mx; req_i = 1'b1; rdy_i = 1'b1;
    @(posedge clk_i);
    forever begin
      @(negedge clk_i);
      if (!hold_req) req_i = 1'b0;
      else begin region_i = ~rg; mux_bus_i = ~mx; end
      if (n + 1 >= base && left > 0) begin rdy_i = 1'b0; left--; end
      else rdy_i = 1'b1;
      #1;
      if (!busy_o || !bus_strb_o) bad = 1;
      n++;
      if (done_o) break;
      if (n > 12) break;
    end
    req_i = 1'b0; rdy_i = 1'b1;
    check({req, " length"}, n, exp);
    check("R9 strobe and busy every cycle", int'(bad), 0);
    @(negedge clk_i);
    #1;
    check("R8 idle after done", int'(busy_o), 0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    #1;
    check("R1 busy after reset", int'(busy_o), 0);
    check("R1 strobe after reset", int'(bus_strb_o), 0);
    check("R1 done after reset", int'(done_o), 0);
    rd_check("R1 mode reset", 2'd0, 8'h00);
    rd_check("R1 csw reset", 2'd1, 8'h00);
    rd_check("R1 prot reset", 2'd2, 8'h00);

    // R6 locked write
    wr(2'd0, 8'hFF);
    rd_check("R6 locked mode write ignored", 2'd0, 8'h00);
    access("R3 internal fast after locked write", 2'd2, 2'd0, 1'b0, 0, 0);
    // R10 register map
    wr(2'd2, 8'hFF);
    rd_check("R10 prot readback", 2'd2, 8'h02);
    wr(2'd1, 8'hAF);
    rd_check("R10 csw readback", 2'd1, 8'hA0);

    // R2, R3, R4, R5 with wait=0, csw=1010
    access("R2 sfr", 2'd0, 2'd0, 1'b0, 0, 0);
    access("R2 display", 2'd1, 2'd3, 1'b1, 0, 0);
    access("R3 internal wait0", 2'd2, 2'd0, 1'b0, 0, 0);
    for (int c = 0; c < 4; c++) begin
      access("R4 external separate", 2'd3, 2'(c), 1'b0, 0, 0);
      access("R5 external mux", 2'd3, 2'(c), 1'b1, 0, 0);
    end

    // R6 unlocked write sets global wait
    wr(2'd0, 8'h80);
    rd_check("R6 unlocked mode write", 2'd0, 8'h80);
    access("R3 internal wait1", 2'd2, 2'd0, 1'b0, 0, 0);
    access("R4 global overrides cs bit", 2'd3, 2'd1, 1'b0, 0, 0);
    access("R2 sfr wait1", 2'd0, 2'd0, 1'b0, 0, 0);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    rd_check("R6 relock keeps wait", 2'd0, 8'h80);

    // R7 ready stalls
    access("R7 stall on waited", 2'd0, 2'd0, 1'b0, 3, 0);
    access("R7 stall on mux", 2'd3, 2'd2, 1'b1, 2, 0);
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h00);
    access("R7 fast ignores ready", 2'd2, 2'd0, 1'b0, 2, 0);
    access("R7 fast external ignores ready", 2'd3, 2'd3, 1'b0, 4, 0);
    // R8 request held during access
    access("R8 held request", 2'd3, 2'd0, 1'b1, 1, 1);

    // random mix
    for (int i = 0; i < 150; i++) begin
      int k;
      k = $urandom_range(0, 5);
      if (k == 0) wr(2'($urandom_range(0, 2)), 8'($urandom));
      access("R2-5 random", 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), $urandom_range(0, 3), bit'($urandom_range(0, 1)));
    end
    rd_check("R10 final mode", 2'd0, {m_wait, 7'd0});
    rd_check("R10 final csw", 2'd1, {m_csw, 4'd0});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule